// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial memory. It holds 256 bytes in registers. It oversamples the clock and data lines with the system clock and separates bus conditions from data bits. It answers its own 7-bit device address, keeps a byte address counter, and serves three kinds of access. A write loads the address counter, then gathers up to four bytes into a page buffer. A random read sets the address first, then issues a repeated start and a read. A sequential read streams bytes for as long as the master acknowledges them. The upper four address bits are the fixed type code 1010. The lower three come from strap inputs, so up to eight such blocks can share one bus.

A page write reaches the array only when a stop ends the transfer, and only after a self-timed busy period measured in system clocks. While the busy period runs, the block ignores its address so that a master can poll it. The write-inhibit input, sampled at the stop, cancels the commit. The block drives the data line through a single pull-low output, and the pad outside it provides the open-drain behaviour.

The controller is one state machine with these states:
- ST_IDLE waits for a start.
- ST_DEV shifts in the address byte. ST_DEV_ACK acknowledges it.
- ST_WADDR takes the word address. ST_WADDR_ACK acknowledges it.
- ST_WDATA takes a data byte. ST_WDATA_ACK acknowledges it.
- ST_RDATA shifts a byte out. ST_RD_ACK samples the master's acknowledge.
- ST_WAIT_STOP sits released after a read that the master did not acknowledge.

Its transitions are:
- From any state, a stop goes to ST_IDLE and a start goes to ST_DEV.
- ST_DEV goes to ST_DEV_ACK on an address match while not busy, and to ST_IDLE otherwise.
- ST_DEV_ACK goes to ST_RDATA for a read and to ST_WADDR for a write.
- ST_WADDR goes to ST_WADDR_ACK, which goes to ST_WDATA.
- ST_WDATA goes to ST_WDATA_ACK, which goes back to ST_WDATA.
- ST_RDATA goes to ST_RD_ACK.
- ST_RD_ACK goes to ST_RDATA on an acknowledge and to ST_WAIT_STOP on a non-acknowledge.

Top module: `eep_2w_slave`

## Requirements
- R1: After reset every array byte reads 0xFF, and sda_pull_o is 0 (line released).
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Until a start is seen, clocked bits get no acknowledge and are otherwise ignored. A stop from any state returns the block to idle.
- R3: The address byte is sent MSB first. Bits 7:4 must equal 1010, bits 3:1 must equal strap_i, and bit 0 is 1 for read and 0 for write. On a match the block pulls SDA low during the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R4: sda_pull_o changes only while the sampled SCL is low, except for the release that follows a start or a stop.
- R5: In a write, the first byte after the address loads the word address counter, and the block acknowledges the word address and every data byte.
- R6: Data bytes of one write go to a four-byte page. Address bits 1:0 advance and wrap within the page while bits 7:2 stay fixed. A fifth or later byte overwrites the buffered byte at its slot.
- R7: A stop after one or more data bytes starts a busy period of BUSY_CYCLES clocks, and the array changes when that period ends. While busy, the block does not acknowledge its address.
- R8: When wr_inhibit_i is high at the stop, the data bytes are still acknowledged, but the array stays unchanged and no busy period starts.
- R9: A read sends the byte at the counter MSB first, and the counter then increments. While the master acknowledges, the following bytes are sent, and the counter wraps from 255 to 0.
- R10: When the master does not acknowledge a read byte, the block keeps SDA released until the next start or stop.
- R11: A repeated start before the stop discards buffered write data, so the array is unchanged and no busy period follows.
- R12: A write of the word address alone, followed by a repeated start and a read, returns the byte at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Low three bits of the device address |
| wr_inhibit_i | input | 1 | High blocks every write commit |
| sda_pull_o | output | 1 | 1 pulls the data line low |

## Verification
The bench clocks a full address byte before any start and expects no acknowledge. It also sends an address with the wrong strap bits and then more bytes without a new start. A design that decodes bytes at any time would acknowledge one of these. A page write that starts in the middle of a page must wrap within that page. A six-byte write must overwrite the first two slots, so a design that carries into bit 2, or keeps the earliest bytes, reads back the wrong order. Polling right after a stop must see no acknowledge. Writes made under inhibit, or abandoned by a repeated start, must leave 0xFF in the array. A sequential read across address 255 must return address 0. After a read that the master does not acknowledge, the line must stay released, so a design that keeps transmitting would pull SDA low under further clocks.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_WAIT_STOP
    } eep_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/eep_line_monitor.sv
module eep_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s     = scl_sync[SYNC_STAGES-1];
    assign sda_s     = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 2,
    parameter int BUSY_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pg_clear,
    input  logic              pg_wr,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [DATA_W-1:0] pg_data,
    input  logic              commit,
    input  logic              inhibit,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PAGE_W;
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);

    logic [DATA_W-1:0]        mem  [DEPTH];
    logic [DATA_W-1:0]        pbuf [SLOTS];
    logic [SLOTS-1:0]         pmask;
    logic [ADDR_W-PAGE_W-1:0] pbase;
    logic [CNT_W-1:0]         busy_cnt;
    logic                     last_tick;

    assign busy      = (busy_cnt != '0);
    assign last_tick = (busy_cnt == CNT_W'(1));
    assign rd_data   = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            pmask    <= '0;
            pbase    <= '0;
            for (int s = 0; s < SLOTS; s++) pbuf[s] <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt - CNT_W'(1);
            if (last_tick) pmask <= '0;
        end else if (commit) begin
            if (!inhibit && (|pmask)) busy_cnt <= BUSY_LOAD;
            else                      pmask    <= '0;
        end else if (pg_clear) begin
            pmask <= '0;
        end else if (pg_wr) begin
            pbuf[pg_addr[PAGE_W-1:0]]  <= pg_data;
            pmask[pg_addr[PAGE_W-1:0]] <= 1'b1;
            pbase                      <= pg_addr[ADDR_W-1:PAGE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (last_tick) begin
            for (int s = 0; s < SLOTS; s++)
                if (pmask[s]) mem[{pbase, PAGE_W'(s)}] <= pbuf[s];
        end
    end
endmodule

// File: rtl/eep_2w_slave.sv
module eep_2w_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 2,
    parameter int BUSY_CYCLES = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wr_inhibit_i,
    output logic       sda_pull_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    eep_state_e state_q, state_d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] shreg, tx, rd_data;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr;
    logic              rw, mack, busy, addr_hit, byte_in;
    logic              pg_wr, pg_clear, commit;

    eep_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_store #(
        .ADDR_W(ADDR_W), .DATA_W(BYTE_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
        .pg_clear(pg_clear), .pg_wr(pg_wr), .pg_addr(addr), .pg_data(shreg),
        .commit(commit), .inhibit(wr_inhibit_i), .busy(busy)
    );

    assign addr_hit = (shreg[7:1] == {DEV_TYPE, strap_i});
    assign byte_in  = scl_fall && (cnt == FULL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEV;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (byte_in) state_d = (addr_hit && !busy) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) state_d = rw ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_in) state_d = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_in) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && cnt == LAST) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_d = mack ? ST_RDATA : ST_WAIT_STOP;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: shifter, bit counter, address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            tx    <= '0;
            cnt   <= '0;
            addr  <= '0;
            rw    <= 1'b0;
            mack  <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else begin
            unique case (state_q)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + CNT_W'(1);
                    end else if (byte_in) begin
                        cnt <= '0;
                        if (state_q == ST_DEV)   rw   <= shreg[0];
                        if (state_q == ST_WADDR) addr <= shreg[ADDR_W-1:0];
                        if (state_q == ST_WDATA)
                            addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
                    end
                end
                ST_DEV_ACK: if (scl_fall && rw) tx <= rd_data;
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx <= {tx[BYTE_W-2:0], 1'b0};
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            addr <= addr + ADDR_W'(1);
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    else if (scl_fall && mack) tx <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = 1'b0;
        unique case (state_q)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA: sda_pull_o = ~tx[BYTE_W-1];
            default:  sda_pull_o = 1'b0;
        endcase
        pg_wr    = (state_q == ST_WDATA) && byte_in && !start_det && !stop_det;
        pg_clear = start_det && !busy;
        commit   = stop_det && ((state_q == ST_WDATA) || (state_q == ST_WDATA_ACK));
    end
endmodule

// File: rtl/eep_2w_checker.sv
module eep_2w_checker
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_pull,
    input logic       busy,
    input logic       wr_inhibit,
    input eep_state_e state
);
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> (!scl_s || $past(start_det || stop_det))); // R4

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull); // R2

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != ST_DEV_ACK)); // R7

    AST_INHIBIT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wr_inhibit)); // R8

    AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_STOP) |-> !sda_pull); // R10
endmodule

bind eep_2w_slave eep_2w_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull_o), .busy(busy),
    .wr_inhibit(wr_inhibit_i), .state(state_q)
);

// File: tb/tb_eep_2w_slave.sv
module tb_eep_2w_slave;
    localparam int BUSY = 300;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic inhibit = 1'b0;
    logic sda_pull;
    logic sda_bus;
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull;

    eep_2w_slave #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .strap_i(STRAP), .wr_inhibit_i(inhibit), .sda_pull_o(sda_pull)
    );

    task automatic gap(input int n = 4);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; gap();
        m_scl = 1'b1; gap();
        m_sda = 1'b0; gap();
        m_scl = 1'b0; gap();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; gap();
        m_scl = 1'b1; gap();
        m_sda = 1'b1; gap();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; gap();
            m_scl = 1'b1; gap();
            m_scl = 1'b0; gap();
        end
        m_sda = 1'b1; gap();
        m_scl = 1'b1; gap(2);
        ack = ~sda_bus;
        gap(2);
        m_scl = 1'b0; gap();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; gap();
            m_scl = 1'b1; gap(2);
            b[i] = sda_bus;
            gap(2);
            m_scl = 1'b0; gap();
        end
        m_sda = ~give_ack; gap();
        m_scl = 1'b1; gap();
        m_scl = 1'b0; gap();
        m_sda = 1'b1;
    endtask

    task automatic set_addr(input logic [7:0] a);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack); check("R12 dev ack", 8'(ack), 8'h01);
        send_byte(a, ack);     check("R5 word addr ack", 8'(ack), 8'h01);
    endtask

    task automatic read_seq(input logic [7:0] a, input int n, output logic [7:0] d [4]);
        logic ack;
        set_addr(a);
        bus_start();
        send_byte(DEV_R, ack); check("R3 read addr ack", 8'(ack), 8'h01);
        for (int k = 0; k < n; k++) recv_byte(d[k], k != n - 1);
        bus_stop();
    endtask

    task automatic write_page(input logic [7:0] a, input logic [7:0] d [6], input int n);
        logic ack;
        set_addr(a);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack);
            check("R5 data ack", 8'(ack), 8'h01);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 released after reset", 8'(sda_pull), 8'h00);
    endtask

    task automatic t_no_start();
        logic ack;
        send_byte(DEV_W, ack);
        check("R2 no ack before start", 8'(ack), 8'h00);
    endtask

    task automatic t_addr();
        logic ack;
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, ack);
        check("R3 wrong strap nack", 8'(ack), 8'h00);
        send_byte(DEV_W, ack);
        check("R3 ignored until start", 8'(ack), 8'h00);
        bus_stop();
        bus_start();
        send_byte(DEV_W, ack);
        check("R3 match ack", 8'(ack), 8'h01);
        bus_stop();
    endtask

    task automatic t_random_read();
        logic [7:0] d [4];
        read_seq(8'h10, 1, d);
        check("R1 R12 erased byte", d[0], 8'hFF);
    endtask

    task automatic t_page();
        logic [7:0] w [6] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h00, 8'h00};
        logic [7:0] d [4];
        logic ack;
        write_page(8'h22, w, 4);
        bus_start();
        send_byte(DEV_W, ack);
        check("R7 busy nack", 8'(ack), 8'h00);
        bus_stop();
        gap(BUSY + 60);
        read_seq(8'h20, 4, d);
        check("R6 slot0", d[0], 8'hC3);
        check("R6 slot1", d[1], 8'hD4);
        check("R7 R9 slot2", d[2], 8'hA1);
        check("R7 R9 slot3", d[3], 8'hB2);
    endtask

    task automatic t_overflow();
        logic [7:0] w [6] = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5};
        logic [7:0] d [4];
        write_page(8'h40, w, 6);
        gap(BUSY + 60);
        read_seq(8'h40, 4, d);
        check("R6 overwrite 0", d[0], 8'hE4);
        check("R6 overwrite 1", d[1], 8'hE5);
        check("R6 kept 2", d[2], 8'hE2);
        check("R6 kept 3", d[3], 8'hE3);
    endtask

    task automatic t_inhibit();
        logic [7:0] w [6] = '{8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        logic [7:0] d [4];
        logic ack;
        inhibit = 1'b1;
        write_page(8'h50, w, 1);
        bus_start();
        send_byte(DEV_W, ack);
        check("R8 no busy after inhibited write", 8'(ack), 8'h01);
        bus_stop();
        inhibit = 1'b0;
        read_seq(8'h50, 1, d);
        check("R8 array unchanged", d[0], 8'hFF);
    endtask

    task automatic t_wrap();
        logic [7:0] w [6] = '{8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00};
        logic [7:0] d [4];
        write_page(8'hFE, w, 2);
        gap(BUSY + 60);
        read_seq(8'hFE, 3, d);
        check("R9 byte FE", d[0], 8'h11);
        check("R9 byte FF", d[1], 8'h22);
        check("R9 wrap to 00", d[2], 8'hFF);
    endtask

    task automatic t_nack();
        logic [7:0] d;
        logic ack;
        logic seen_low = 1'b0;
        set_addr(8'h20);
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(d, 1'b0);
        check("R10 byte before nack", d, 8'hC3);
        for (int i = 0; i < 9; i++) begin
            m_sda = 1'b1; gap();
            m_scl = 1'b1; gap(2);
            if (!sda_bus) seen_low = 1'b1;
            gap(2);
            m_scl = 1'b0; gap();
        end
        check("R10 line released after nack", 8'(seen_low), 8'h00);
        bus_stop();
        check("R2 idle after stop", 8'(sda_pull), 8'h00);
    endtask

    task automatic t_restart();
        logic [7:0] d;
        logic ack;
        set_addr(8'h60);
        send_byte(8'h77, ack);
        check("R5 data ack before restart", 8'(ack), 8'h01);
        set_addr(8'h60);
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(d, 1'b0);
        bus_stop();
        check("R11 discarded data", d, 8'hFF);
        bus_start();
        send_byte(DEV_W, ack);
        check("R11 no busy", 8'(ack), 8'h01);
        bus_stop();
    endtask

    initial begin
        gap(5);
        rst_n = 1'b1;
        gap(5);
        t_reset();
        t_no_start();
        bus_stop();
        t_addr();
        t_random_read();
        t_page();
        t_overflow();
        t_inhibit();
        t_wrap();
        t_nack();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule